// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block decides which of five interrupt causes in a 16550-style serial port is reported to the processor. It drives a single interrupt line. Each cycle it sees the enable bits, the line-error flags, the receive state, the character-timeout flag, the holding-register-empty flag and the modem delta bits. From these it forms the identification byte that software reads to learn the cause, and it raises the interrupt whenever some enabled cause is active.

Only one cause is kept as state in the block: the transmit-empty pending flag. It is set when the holding register becomes empty, or when software turns on the transmit-empty enable while the register is already empty. It is cleared when software reads the identification byte while that byte shows the transmit-empty cause, when the holding register fills, or when the enable is turned off. The FIFOs, the serializer and the baud generator sit outside the block and appear as plain inputs.

Top module: `uart_irq_ident`

## Requirements
- R1: Causes are ranked, from highest to lowest: line error, character timeout, receive data, transmit empty, modem change. Only the highest active enabled cause appears in `iir_code[3:0]`.
- R2: When `ier_en[2]` is 1 and any bit of `lsr_err` (break, framing, parity, overrun) is 1, the code is 0x6.
- R3: When `ier_en[0]` is 1 and `char_tmo` is 1, the code is 0xC. When `ier_en[0]` is 0, the timeout cause is ignored.
- R4: When `ier_en[0]` and `rx_ready` are both 1, the code is 0x4. This requires either that `fifo_on` is 0, or that `rx_count` is at least `trig_level` (a count equal to the level qualifies).
- R5: When `ier_en[1]` is 1 and the pending flag is set, the code is 0x2. A 0-to-1 change of `thr_empty` sets the flag at the next clock edge. A 1-to-0 change clears it at the next clock edge.
- R6: A cycle with `iir_rd` high while the code reads 0x2 clears the pending flag at that clock edge. A read while a different code is shown leaves the flag unchanged.
- R7: A change of `ier_en[1]` overrides all other updates. The flag becomes 1 if `ier_en[1]` is now 1 and `thr_empty` is 1. In every other case it becomes 0.
- R8: When `ier_en[3]` is 1 and any bit of `msr_delta` is 1, the code is 0x0.
- R9: With no cause active, `iir_code[3:0]` is 0x1 and `irq` is 0. Otherwise `irq` is 1. Both follow input changes in the same cycle, with no clock edge in between.
- R10: `iir_code[7:6]` is 11 when `fifo_on` is 1 and 00 when it is 0. `iir_code[5:4]` is always 00.
- R11: A synchronous active-low reset clears the pending flag. While the block is in reset, and with no other cause active, `iir_code` reads 0x01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ier_en | input | 4 | Enables: bit0 receive data and timeout, bit1 transmit empty, bit2 line error, bit3 modem change |
| lsr_err | input | 4 | Line error flags: break, framing, parity, overrun |
| rx_ready | input | 1 | Received data available |
| fifo_on | input | 1 | FIFO mode active |
| rx_count | input | CNT_W | Bytes held in the receive FIFO |
| trig_level | input | CNT_W | Receive trigger level |
| char_tmo | input | 1 | Character timeout pending |
| thr_empty | input | 1 | Transmit holding register empty |
| msr_delta | input | 4 | Modem status delta bits |
| iir_rd | input | 1 | Identification register read strobe |
| iir_code | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is the pending flag when several of its update rules act in the same cycle. Examples are a read that coincides with a change of the enable bit or of `thr_empty`, and a read taken while a higher cause hides the transmit-empty code. An exhaustive sweep walks a 12-bit input vector through every combination, one combination per cycle. Consecutive vectors therefore toggle the enable bit, the empty flag and the read strobe against one another. A reference model built from the update rules predicts the flag. Directed sequences then cover the fill threshold, re-arming through the enable bit, and a read that must leave the flag set.

// File: rtl/uirq_pkg.sv
// Shared definitions for the interrupt identification block.
// Assumes a 4-bit identification code in the low nibble.
package uirq_pkg;
    typedef enum logic [3:0] {
        CAUSE_MODEM   = 4'h0,
        CAUSE_NONE    = 4'h1,
        CAUSE_THRE    = 4'h2,
        CAUSE_RXDATA  = 4'h4,
        CAUSE_LINE    = 4'h6,
        CAUSE_TIMEOUT = 4'hC
    } cause_e;

    localparam int EN_RX    = 0;
    localparam int EN_THR   = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;
endpackage

// File: rtl/uirq_cause_sel.sv
// Priority selection of the active interrupt cause.
// Purely combinational. Assumes rx_count and trig_level share one width.
module uirq_cause_sel
    import uirq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic [3:0]       ier_en,
    input  logic [3:0]       lsr_err,
    input  logic             rx_ready,
    input  logic             fifo_on,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] trig_level,
    input  logic             char_tmo,
    input  logic             thre_pend,
    input  logic [3:0]       msr_delta,
    output cause_e           cause
);
    logic line_act, tmo_act, rx_act, thr_act, mdm_act, fill_ok;

    // Decide which individual causes are active.
    always_comb begin
        fill_ok  = !fifo_on || (rx_count >= trig_level);
        line_act = ier_en[EN_LINE] && (|lsr_err);
        tmo_act  = ier_en[EN_RX] && char_tmo;
        rx_act   = ier_en[EN_RX] && rx_ready && fill_ok;
        thr_act  = ier_en[EN_THR] && thre_pend;
        mdm_act  = ier_en[EN_MODEM] && (|msr_delta);
    end

    // Report the highest-ranked active cause.
    always_comb begin
        if (line_act)     cause = CAUSE_LINE;
        else if (tmo_act) cause = CAUSE_TIMEOUT;
        else if (rx_act)  cause = CAUSE_RXDATA;
        else if (thr_act) cause = CAUSE_THRE;
        else if (mdm_act) cause = CAUSE_MODEM;
        else              cause = CAUSE_NONE;
    end
endmodule

// File: rtl/uirq_thre_track.sv
// Holds the sticky transmit-empty pending flag.
// Update order in one cycle: a read clear, then thr_empty edges, and above
// both any change of the enable bit. Assumes rd_thre arrives already qualified.
module uirq_thre_track (
    input  logic clk,
    input  logic rst_n,
    input  logic ier_thr,
    input  logic thr_empty,
    input  logic rd_thre,
    output logic pend
);
    logic ier_q, thr_q, pend_nx;

    // Work out the next value of the flag.
    always_comb begin
        pend_nx = pend;
        if (rd_thre)               pend_nx = 1'b0;
        if (thr_empty && !thr_q)   pend_nx = 1'b1;
        if (!thr_empty && thr_q)   pend_nx = 1'b0;
        if (ier_thr != ier_q)      pend_nx = ier_thr && thr_empty;
    end

    // Register the flag and the edge-detect history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend  <= 1'b0;
            ier_q <= 1'b0;
            thr_q <= 1'b1;
        end else begin
            pend  <= pend_nx;
            ier_q <= ier_thr;
            thr_q <= thr_empty;
        end
    end

    assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_thre && (ier_thr == ier_q) && !(thr_empty && !thr_q)) |=> !pend);

    assert_enable_arms_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((ier_thr != ier_q) && ier_thr && thr_empty) |=> pend);

    assert_enable_off_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((ier_thr != ier_q) && !ier_thr) |=> !pend);
endmodule

// File: rtl/uart_irq_ident.sv
// Top of the interrupt identification block: combines the cause selector and
// the pending-flag tracker, forms the identification byte and the line.
// Assumes the read strobe lasts one cycle for each software read.
module uart_irq_ident
    import uirq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       ier_en,
    input  logic [3:0]       lsr_err,
    input  logic             rx_ready,
    input  logic             fifo_on,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] trig_level,
    input  logic             char_tmo,
    input  logic             thr_empty,
    input  logic [3:0]       msr_delta,
    input  logic             iir_rd,
    output logic [7:0]       iir_code,
    output logic             irq
);
    cause_e cause;
    logic   thre_pend;
    logic   rd_thre;

    uirq_cause_sel #(.CNT_W(CNT_W)) u_sel (
        .ier_en     (ier_en),
        .lsr_err    (lsr_err),
        .rx_ready   (rx_ready),
        .fifo_on    (fifo_on),
        .rx_count   (rx_count),
        .trig_level (trig_level),
        .char_tmo   (char_tmo),
        .thre_pend  (thre_pend),
        .msr_delta  (msr_delta),
        .cause      (cause)
    );

    uirq_thre_track u_thre (
        .clk       (clk),
        .rst_n     (rst_n),
        .ier_thr   (ier_en[EN_THR]),
        .thr_empty (thr_empty),
        .rd_thre   (rd_thre),
        .pend      (thre_pend)
    );

    // Qualify a read with the transmit-empty code and build the outputs.
    always_comb begin
        rd_thre  = iir_rd && (cause == CAUSE_THRE);
        iir_code = {{2{fifo_on}}, 2'b00, cause};
        irq      = (cause != CAUSE_NONE);
    end

    assert_line_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_en[EN_LINE] && (|lsr_err)) |-> (iir_code[3:0] == 4'h6));

    assert_rx_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ier_en[EN_RX] |-> ((iir_code[3:0] != 4'hC) && (iir_code[3:0] != 4'h4)));

    assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (iir_code[3:0] == 4'h1));

    assert_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|ier_en));

    assert_spare_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
        iir_code[5:4] == 2'b00);
endmodule

// File: tb/test_uart_irq_ident.sv
module test_uart_irq_ident;
    localparam int CNT_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [3:0]       ier_en = '0;
    logic [3:0]       lsr_err = '0;
    logic             rx_ready = 1'b0;
    logic             fifo_on = 1'b0;
    logic [CNT_W-1:0] rx_count = '0;
    logic [CNT_W-1:0] trig_level = '0;
    logic             char_tmo = 1'b0;
    logic             thr_empty = 1'b1;
    logic [3:0]       msr_delta = '0;
    logic             iir_rd = 1'b0;
    logic [7:0]       iir_code;
    logic             irq;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    uart_irq_ident #(.CNT_W(CNT_W)) i_uart_irq_ident (
        .clk(clk), .rst_n(rst_n), .ier_en(ier_en), .lsr_err(lsr_err),
        .rx_ready(rx_ready), .fifo_on(fifo_on), .rx_count(rx_count),
        .trig_level(trig_level), .char_tmo(char_tmo), .thr_empty(thr_empty),
        .msr_delta(msr_delta), .iir_rd(iir_rd), .iir_code(iir_code), .irq(irq)
    );

    // Reference: expected low nibble, from the ranked causes.
    function automatic logic [3:0] ref_code(input logic pend);
        if (ier_en[2] && |lsr_err) return 4'h6;
        if (ier_en[0] && char_tmo) return 4'hC;
        if (ier_en[0] && rx_ready && (!fifo_on || rx_count >= trig_level)) return 4'h4;
        if (ier_en[1] && pend) return 4'h2;
        if (ier_en[3] && |msr_delta) return 4'h0;
        return 4'h1;
    endfunction

    // Reference pending flag, built from R5, R6, R7 and R11.
    logic m_pend, m_ier1, m_thr;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend <= 1'b0; m_ier1 <= 1'b0; m_thr <= 1'b1;
        end else begin
            logic n;
            n = m_pend;
            if (iir_rd && ref_code(m_pend) == 4'h2) n = 1'b0;
            if (thr_empty && !m_thr) n = 1'b1;
            if (!thr_empty && m_thr) n = 1'b0;
            if (ier_en[1] != m_ier1) n = ier_en[1] && thr_empty;
            m_pend <= n; m_ier1 <= ier_en[1]; m_thr <= thr_empty;
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] ie, input logic [3:0] le, input logic rdy,
                         input logic fo, input int cnt, input int trg, input logic tmo,
                         input logic te, input logic [3:0] md, input logic rd);
        @(negedge clk);
        ier_en = ie; lsr_err = le; rx_ready = rdy; fifo_on = fo;
        rx_count = CNT_W'(cnt); trig_level = CNT_W'(trg); char_tmo = tmo;
        thr_empty = te; msr_delta = md; iir_rd = rd;
        #1;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R11: reset with transmit-empty enabled and holding register empty
        drive(4'h2, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        drive(4'h2, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        drive(4'h2, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        check("R11 code in reset", iir_code, 8'h01);
        check("R11 irq in reset", {7'b0, irq}, 8'h00);
        @(negedge clk); rst_n = 1'b1; ier_en = 4'h0; #1;
        check("R11 code after reset", iir_code, 8'h01);

        // R7: enable rises with empty register -> pending next cycle
        drive(4'h2, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        check("R7 not yet armed", iir_code, 8'h01);
        drive(4'h2, 0, 0, 0, 0, 0, 0, 1, 0, 1);
        check("R7 armed", iir_code, 8'h02);
        check("R9 irq high", {7'b0, irq}, 8'h01);
        // R6: that read clears the flag
        drive(4'h2, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        check("R6 read clears", iir_code, 8'h01);
        check("R9 irq low", {7'b0, irq}, 8'h00);
        // R7: toggle enable off and on to re-arm
        drive(4'h0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        drive(4'h2, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        drive(4'h2, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        check("R7 re-armed", iir_code, 8'h02);
        // R5: holding register fills -> flag clears
        drive(4'h2, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        drive(4'h2, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        check("R5 fill clears", iir_code, 8'h01);
        // R7: enable rises while not empty -> no pending
        drive(4'h0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        drive(4'h2, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        drive(4'h2, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        check("R7 no arm when full", iir_code, 8'h01);
        // R5: register becomes empty -> flag set
        drive(4'h2, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        drive(4'h2, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        check("R5 empty edge sets", iir_code, 8'h02);
        // R1 and R6: receive data hides the flag, and a read of 0x4 keeps it
        drive(4'h3, 0, 1, 0, 0, 0, 0, 1, 0, 1);
        check("R1 rx over thre", iir_code, 8'h04);
        drive(4'h3, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        check("R6 other read keeps flag", iir_code, 8'h02);
        // R4 and R10: fill threshold with FIFOs on
        drive(4'h1, 0, 1, 1, 8, 8, 0, 1, 0, 0);
        check("R4 count equals level", iir_code, 8'hC4);
        drive(4'h1, 0, 1, 1, 7, 8, 0, 1, 0, 0);
        check("R4 count below level", iir_code, 8'hC1);
        check("R9 irq low below level", {7'b0, irq}, 8'h00);
        drive(4'h1, 0, 1, 0, 0, 8, 0, 1, 0, 0);
        check("R4 no FIFO", iir_code, 8'h04);
        // R3: timeout masked and unmasked
        drive(4'h0, 0, 0, 1, 0, 0, 1, 1, 0, 0);
        check("R3 masked timeout", iir_code, 8'hC1);
        drive(4'h1, 0, 0, 1, 0, 0, 1, 1, 0, 0);
        check("R3 timeout", iir_code, 8'hCC);
        // R8: modem change
        drive(4'h8, 0, 0, 0, 0, 0, 0, 1, 4'b0100, 0);
        check("R8 modem", iir_code, 8'h00);
        check("R8 irq", {7'b0, irq}, 8'h01);
        // R2: each line error bit alone
        for (int b = 0; b < 4; b++) begin
            drive(4'hF, 4'(1 << b), 1, 0, 0, 0, 1, 1, 4'hF, 0);
            check("R2 line error", iir_code, 8'h06);
        end

        // R1: exhaustive sweep against the reference model
        for (int i = 0; i < 4096; i++) begin
            logic [3:0] e;
            string tag;
            drive(4'(i), i[4] ? 4'b1000 : 4'b0000, i[6], i[7], i[8] ? 10 : 3, 8,
                  i[5], i[10], i[9] ? 4'b0010 : 4'b0000, i[11]);
            e = ref_code(m_pend);
            case (e)
                4'h6: tag = "R1/R2 sweep";
                4'hC: tag = "R1/R3 sweep";
                4'h4: tag = "R1/R4 sweep";
                4'h2: tag = "R1/R5 sweep";
                4'h0: tag = "R1/R8 sweep";
                default: tag = "R1/R9 sweep";
            endcase
            check(tag, iir_code, {{2{fifo_on}}, 2'b00, e});
            check("R9 sweep irq", {7'b0, irq}, {7'b0, e != 4'h1});
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule